// File: doc/BRIEF.md
# Inter-Processor Mailbox Bank

A bank of hardware mailboxes on a 32-bit register bus, used by several processors to pass short commands to one another and to get acknowledgments back. Each processor has a one-hot source identifier and one interrupt output. A requester first claims a free mailbox by writing its identifier to the owner register and reading it back. It then fills the payload words, names the destinations, and posts the message with a send write. It polls the state nibble of the mode register until the acknowledge code appears, clears its own interrupt, and releases the mailbox by writing its identifier to the owner register once more.

Every mailbox runs a four-state machine. IDLE (code 0x1) moves to OWNED (0x4) on a claim. OWNED moves to SENT (0x2) on a send from the owner. SENT moves to ACKED (0x8) on an answer, which is a send from a destination while auto-answer is on. Release takes OWNED, SENT or ACKED back to IDLE. A global key register guards every mailbox write. Interrupts are raised per source, kept pending per mailbox, and can be masked per mailbox.

Top module: `mbox_bank`

## Requirements
- R1: After reset the lock register at 0xA00 reads 0 and every mailbox is in IDLE. Its owner reads 0, its mode register reads exactly 0x10, and all `irq` bits are 0.
- R2: A write of 0x1ACCE551 to 0xA00 unlocks the bank, and the lock register then reads 1. A write of any other value to 0xA00 locks it again. While the bank is locked, writes to mailbox registers have no effect. Reads work at all times.
- R3: Mailbox m occupies bytes m*64 to m*64+63. Its owner register is at +0x00. While the mailbox is IDLE, a write of a value with exactly one of bits 0..5 set and every other bit 0 claims it. The owner then reads back that value, and mode bits [7:4] read 0x4. A zero or multi-bit value is ignored.
- R4: While the mailbox is not IDLE, a write to the owner register of a value other than the current owner leaves the owner and the state unchanged.
- R5: A write to +0x04 ORs bits into the destination set. A write to +0x08 clears the written bits from it. +0x0C reads the destination set.
- R6: A send is a write of the owner's identifier to +0x1C in OWNED. It moves the mode nibble to 0x2 and sets a pending flag for every source in the destination set. A send write of any other value in OWNED is ignored.
- R7: Mode register +0x10 reads {state[3:0], 3'b0, auto}. Writes to bit 0 set auto while the mailbox is not IDLE and are ignored in IDLE. In SENT with auto=1, a write to +0x1C of a one-hot destination identifier moves the mode nibble to 0x8 and sets the owner's pending flag. With auto=0 the same write changes nothing.
- R8: Mask register +0x14 holds six bits, and a 1 suppresses that source in that mailbox. `irq[p]` is the OR over all mailboxes of (pending & ~mask) for source p. The word at 0x800+8*p reads, in bit m, the unmasked pending flag of mailbox m for source p.
- R9: A write to +0x18 clears the pending flags of the sources whose bits are set.
- R10: In OWNED, SENT or ACKED, a write of the current owner's identifier to +0x00 releases the mailbox. The state returns to IDLE, the owner reads 0 and auto clears, so the mode register reads 0x10.
- R11: Eight payload words per mailbox at +0x20+4*k are readable and writable in any state, up to and including the last mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 6 | One interrupt per source |

## Verification
The full claim, send, answer, clear and release handshake runs on mailbox 13 with a mask that leaves only the owner and the destination unmasked. This separates the pending flags raised by a send from those raised by an answer. A competing claim, a non-owner send and a destination answer with auto-answer off show that each gate depends on who writes, not only on the register written. Malformed identifiers, masking and unmasking of a live pending flag, destination set against clear, and writes attempted before the key and after relocking separate the state gating from the lock gating.

// File: rtl/mbox_bank_pkg.sv
package mbox_bank_pkg;

    localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

    // state codes as they appear in mode bits [7:4]
    typedef enum logic [3:0] {
        ST_IDLE  = 4'h1,
        ST_SENT  = 4'h2,
        ST_OWNED = 4'h4,
        ST_ACKED = 4'h8
    } mbox_state_e;

    // word offsets inside one 64-byte mailbox window
    localparam logic [3:0] OFF_OWNER = 4'h0;
    localparam logic [3:0] OFF_DSET  = 4'h1;
    localparam logic [3:0] OFF_DCLR  = 4'h2;
    localparam logic [3:0] OFF_DSTAT = 4'h3;
    localparam logic [3:0] OFF_MODE  = 4'h4;
    localparam logic [3:0] OFF_MASK  = 4'h5;
    localparam logic [3:0] OFF_ICLR  = 4'h6;
    localparam logic [3:0] OFF_SEND  = 4'h7;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
    parameter int ADDR_W   = 12,
    parameter int NUM_MBOX = 18,
    parameter int NUM_SRC  = 6,
    localparam int IDX_W   = $clog2(NUM_MBOX),
    localparam int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              slot_hit,
    output logic [IDX_W-1:0]  slot_idx,
    output logic [3:0]        off,
    output logic              stat_hit,
    output logic [SRC_W-1:0]  stat_idx,
    output logic              lock_hit
);
    localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'('h800);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'('hA00);
    localparam logic [ADDR_W-7:0] NM_W      = NUM_MBOX[ADDR_W-7:0];
    localparam logic [4:0]        NS_W      = NUM_SRC[4:0];

    logic aligned;
    logic [ADDR_W-7:0] win;

    always_comb begin
        aligned  = (addr[1:0] == 2'b00);
        win      = addr[ADDR_W-1:6];
        slot_hit = aligned && (win < NM_W);
        slot_idx = win[IDX_W-1:0];
        off      = addr[5:2];
        stat_hit = (addr[ADDR_W-1:8] == STAT_BASE[ADDR_W-1:8]) &&
                   (addr[2:0] == 3'b000) && (addr[7:3] < NS_W);
        stat_idx = addr[3+SRC_W-1:3];
        lock_hit = (addr == LOCK_ADDR);
    end
endmodule

// File: rtl/mbox_slot.sv
module mbox_slot
    import mbox_bank_pkg::*;
#(
    parameter int NUM_SRC    = 6,
    parameter int DATA_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         off,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] mask_o
);
    localparam logic [3:0] DW4 = DATA_WORDS[3:0];

    mbox_state_e state_q, state_d;
    logic [NUM_SRC-1:0] owner_q, owner_d;
    logic [NUM_SRC-1:0] dest_q, pend_q, pend_d, mask_q;
    logic               auto_q, auto_d;
    logic [31:0]        data_q [DATA_WORDS];

    logic [NUM_SRC-1:0] id;
    logic id_ok, data_sel;
    logic wr_owner, wr_mode, wr_send, wr_iclr, release_req;

    always_comb begin
        id          = wr_data[NUM_SRC-1:0];
        id_ok       = (wr_data[31:NUM_SRC] == '0) && (id != '0) &&
                      ((id & (id - 1'b1)) == '0);
        data_sel    = off[3] && ({1'b0, off[2:0]} < DW4);
        wr_owner    = wr_en && (off == OFF_OWNER);
        wr_mode     = wr_en && (off == OFF_MODE);
        wr_send     = wr_en && (off == OFF_SEND);
        wr_iclr     = wr_en && (off == OFF_ICLR);
        release_req = wr_owner && id_ok && (id == owner_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            auto_q  <= 1'b0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            auto_q  <= auto_d;
            pend_q  <= pend_d;
        end
    end

    // transitions and their effects
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        auto_d  = auto_q;
        pend_d  = pend_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_owner && id_ok) begin
                    state_d = ST_OWNED;
                    owner_d = id;
                end
            end
            ST_OWNED: begin
                if (release_req) begin
                    state_d = ST_IDLE;
                    owner_d = '0;
                    auto_d  = 1'b0;
                end else if (wr_mode) begin
                    auto_d = wr_data[0];
                end else if (wr_send && id_ok && (id == owner_q)) begin
                    state_d = ST_SENT;
                    pend_d  = pend_q | dest_q;
                end
            end
            ST_SENT: begin
                if (release_req) begin
                    state_d = ST_IDLE;
                    owner_d = '0;
                    auto_d  = 1'b0;
                end else if (wr_mode) begin
                    auto_d = wr_data[0];
                end else if (wr_send && id_ok && auto_q && ((id & dest_q) != '0)) begin
                    state_d = ST_ACKED;
                    pend_d  = pend_q | owner_q;
                end
            end
            ST_ACKED: begin
                if (release_req) begin
                    state_d = ST_IDLE;
                    owner_d = '0;
                    auto_d  = 1'b0;
                end else if (wr_mode) begin
                    auto_d = wr_data[0];
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (wr_iclr) pend_d = pend_q & ~id;
    end

    // destination set, mask and payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_q <= '0;
            mask_q <= '0;
            for (int k = 0; k < DATA_WORDS; k++) data_q[k] <= '0;
        end else if (wr_en) begin
            if (off == OFF_DSET) dest_q <= dest_q | id;
            if (off == OFF_DCLR) dest_q <= dest_q & ~id;
            if (off == OFF_MASK) mask_q <= id;
            if (data_sel) data_q[off[2:0]] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        case (off)
            OFF_OWNER: rd_data = 32'(owner_q);
            OFF_DSTAT: rd_data = 32'(dest_q);
            OFF_MODE:  rd_data = {24'b0, state_q, 3'b000, auto_q};
            OFF_MASK:  rd_data = 32'(mask_q);
            default:   if (data_sel) rd_data = data_q[off[2:0]];
        endcase
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    // R3
    claim_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_owner && id_ok) |=>
        (state_q == ST_OWNED && owner_q == $past(id)));
    // R4
    claim_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && wr_owner && id != owner_q) |=>
        ($stable(owner_q) && $stable(state_q)));
    // R6
    send_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWNED && wr_send && id_ok && id == owner_q) |=>
        (state_q == ST_SENT && (pend_q & $past(dest_q)) == $past(dest_q)));
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && wr_owner && id_ok && id == owner_q) |=>
        (state_q == ST_IDLE && owner_q == '0 && !auto_q));
    // R1
    idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (owner_q == '0 && !auto_q));
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
    parameter int NUM_MBOX = 18,
    parameter int NUM_SRC  = 6
) (
    input  logic [NUM_MBOX*NUM_SRC-1:0] pend_flat,
    input  logic [NUM_MBOX*NUM_SRC-1:0] mask_flat,
    output logic [NUM_MBOX*NUM_SRC-1:0] stat_flat,
    output logic [NUM_SRC-1:0]          irq_o
);
    // stat_flat[p*NUM_MBOX + m]: source p, mailbox m
    for (genvar p = 0; p < NUM_SRC; p++) begin : g_src
        for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
            assign stat_flat[p*NUM_MBOX + m] =
                pend_flat[m*NUM_SRC + p] & ~mask_flat[m*NUM_SRC + p];
        end
        assign irq_o[p] = |stat_flat[p*NUM_MBOX +: NUM_MBOX];
    end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_bank_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_MBOX   = 18,
    parameter int NUM_SRC    = 6,
    parameter int DATA_WORDS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_SRC-1:0] irq
);
    localparam int IDX_W = $clog2(NUM_MBOX);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic             slot_hit, stat_hit, lock_hit, unlocked_q;
    logic [IDX_W-1:0] slot_idx;
    logic [SRC_W-1:0] stat_idx;
    logic [3:0]       off;
    logic [31:0]      slot_rd [NUM_MBOX];
    logic [NUM_MBOX*NUM_SRC-1:0] pend_flat, mask_flat, stat_flat;
    logic [NUM_MBOX-1:0] stat_word;

    mbox_decode #(.ADDR_W(ADDR_W), .NUM_MBOX(NUM_MBOX), .NUM_SRC(NUM_SRC)) u_dec (
        .addr(bus_addr), .slot_hit(slot_hit), .slot_idx(slot_idx), .off(off),
        .stat_hit(stat_hit), .stat_idx(stat_idx), .lock_hit(lock_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                unlocked_q <= 1'b0;
        else if (bus_we && lock_hit) unlocked_q <= (bus_wdata == UNLOCK_KEY);
    end

    for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
        mbox_slot #(.NUM_SRC(NUM_SRC), .DATA_WORDS(DATA_WORDS)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_we && unlocked_q && slot_hit && (slot_idx == IDX_W'(m))),
            .off(off), .wr_data(bus_wdata), .rd_data(slot_rd[m]),
            .pend_o(pend_flat[m*NUM_SRC +: NUM_SRC]),
            .mask_o(mask_flat[m*NUM_SRC +: NUM_SRC])
        );
    end

    mbox_irq #(.NUM_MBOX(NUM_MBOX), .NUM_SRC(NUM_SRC)) u_irq (
        .pend_flat(pend_flat), .mask_flat(mask_flat),
        .stat_flat(stat_flat), .irq_o(irq)
    );

    always_comb begin
        stat_word = stat_flat[stat_idx*NUM_MBOX +: NUM_MBOX];
        bus_rdata = '0;
        if (slot_hit)      bus_rdata = slot_rd[slot_idx];
        else if (stat_hit) bus_rdata = 32'(stat_word);
        else if (lock_hit) bus_rdata = {31'b0, unlocked_q};
    end

    // R2
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && lock_hit && bus_wdata == UNLOCK_KEY) |=> unlocked_q);
    // R2
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && lock_hit && bus_wdata != UNLOCK_KEY) |=> !unlocked_q);
endmodule

// File: tb/mbox_bank_test.sv
`timescale 1ns/1ps
module mbox_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;
    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    mbox_bank uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    typedef struct packed {
        logic [11:0] addr;
        logic        we;
        logic [31:0] data;   // write data, or expected read data
        logic [5:0]  irq;    // expected irq on read rows
        logic [3:0]  req;
    } vec_t;

    // full handshake on mailbox 13 (window 0x340)
    localparam vec_t VEC [31] = '{
        '{12'hA00, 1'b1, 32'h1ACCE551, 6'h00, 4'd2},  // R2 unlock
        '{12'hA00, 1'b0, 32'h00000001, 6'h00, 4'd2},  // R2
        '{12'h350, 1'b0, 32'h00000010, 6'h00, 4'd1},  // R1
        '{12'h340, 1'b1, 32'h00000001, 6'h00, 4'd3},  // R3 claim
        '{12'h340, 1'b0, 32'h00000001, 6'h00, 4'd3},
        '{12'h350, 1'b0, 32'h00000040, 6'h00, 4'd3},
        '{12'h340, 1'b1, 32'h00000002, 6'h00, 4'd4},  // R4 competing claim
        '{12'h340, 1'b0, 32'h00000001, 6'h00, 4'd4},
        '{12'h350, 1'b1, 32'h00000001, 6'h00, 4'd7},  // R7 auto on
        '{12'h350, 1'b0, 32'h00000041, 6'h00, 4'd7},
        '{12'h344, 1'b1, 32'h00000008, 6'h00, 4'd5},  // R5
        '{12'h34C, 1'b0, 32'h00000008, 6'h00, 4'd5},
        '{12'h354, 1'b1, 32'h00000036, 6'h00, 4'd8},  // R8 mask
        '{12'h360, 1'b1, 32'h00010003, 6'h00, 4'd11}, // R11
        '{12'h364, 1'b1, 32'h00000005, 6'h00, 4'd11},
        '{12'h360, 1'b0, 32'h00010003, 6'h00, 4'd11},
        '{12'h35C, 1'b1, 32'h00000002, 6'h00, 4'd6},  // R6 non-owner send
        '{12'h350, 1'b0, 32'h00000041, 6'h00, 4'd6},
        '{12'h35C, 1'b1, 32'h00000001, 6'h00, 4'd6},  // R6 send
        '{12'h350, 1'b0, 32'h00000021, 6'h08, 4'd6},
        '{12'h818, 1'b0, 32'h00002000, 6'h08, 4'd8},  // R8 status src3
        '{12'h358, 1'b1, 32'h00000008, 6'h00, 4'd9},  // R9
        '{12'h818, 1'b0, 32'h00000000, 6'h00, 4'd9},
        '{12'h35C, 1'b1, 32'h00000008, 6'h00, 4'd7},  // R7 answer
        '{12'h350, 1'b0, 32'h00000081, 6'h01, 4'd7},
        '{12'h800, 1'b0, 32'h00002000, 6'h01, 4'd8},
        '{12'h358, 1'b1, 32'h00000001, 6'h00, 4'd9},
        '{12'h800, 1'b0, 32'h00000000, 6'h00, 4'd9},
        '{12'h340, 1'b1, 32'h00000001, 6'h00, 4'd10}, // R10 release
        '{12'h350, 1'b0, 32'h00000010, 6'h00, 4'd10},
        '{12'h340, 1'b0, 32'h00000000, 6'h00, 4'd10}
    };

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [11:0] a, input logic [31:0] exp_d,
                       input logic [5:0] exp_irq, input string tag);
        @(negedge clk);
        bus_addr = a;
        #2;
        tests++;
        if (bus_rdata !== exp_d || irq !== exp_irq) begin
            fails++;
            $display("FAIL %s addr=%h rdata=%h exp=%h irq=%h exp_irq=%h",
                     tag, a, bus_rdata, exp_d, irq, exp_irq);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(12'hA00, 32'h0, 6'h0, "R1");
        chk(12'h010, 32'h10, 6'h0, "R1");
        chk(12'h440, 32'h0, 6'h0, "R1");
        // R2 locked: claim ignored
        wr(12'h000, 32'h1);
        chk(12'h000, 32'h0, 6'h0, "R2");

        for (int i = 0; i < 31; i++) begin
            if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
            else chk(VEC[i].addr, VEC[i].data, VEC[i].irq,
                     $sformatf("R%0d row %0d", VEC[i].req, i));
        end

        // R3 malformed identifiers
        wr(12'h040, 32'h3);
        chk(12'h040, 32'h0, 6'h0, "R3");
        wr(12'h040, 32'h40);
        chk(12'h040, 32'h0, 6'h0, "R3");
        // R7 mode write ignored while idle
        wr(12'h050, 32'h1);
        chk(12'h050, 32'h10, 6'h0, "R7");
        // R6 send on mailbox 1 with auto off
        wr(12'h040, 32'h4);
        wr(12'h044, 32'h1);
        wr(12'h05C, 32'h4);
        chk(12'h050, 32'h20, 6'h01, "R6");
        chk(12'h800, 32'h2, 6'h01, "R8");
        // R7 answer without auto has no effect
        wr(12'h05C, 32'h1);
        chk(12'h050, 32'h20, 6'h01, "R7");
        // R8 mask
        wr(12'h054, 32'h1);
        chk(12'h800, 32'h0, 6'h00, "R8");
        wr(12'h054, 32'h0);
        chk(12'h800, 32'h2, 6'h01, "R8");
        // R9 clear
        wr(12'h058, 32'h1);
        chk(12'h800, 32'h0, 6'h00, "R9");
        // R10 release from SENT
        wr(12'h040, 32'h4);
        chk(12'h050, 32'h10, 6'h0, "R10");
        chk(12'h040, 32'h0, 6'h0, "R10");
        // R5 destination clear
        wr(12'h048, 32'h1);
        chk(12'h04C, 32'h0, 6'h0, "R5");
        wr(12'h044, 32'h6);
        wr(12'h048, 32'h2);
        chk(12'h04C, 32'h4, 6'h0, "R5");
        // R11 last mailbox, last word
        wr(12'h47C, 32'hCAFEF00D);
        chk(12'h47C, 32'hCAFEF00D, 6'h0, "R11");
        chk(12'h460, 32'h0, 6'h0, "R11");
        // R2 relock
        wr(12'hA00, 32'h0);
        chk(12'hA00, 32'h0, 6'h0, "R2");
        wr(12'h360, 32'h0000DEAD);
        chk(12'h360, 32'h00010003, 6'h0, "R2");

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule